// File: doc/BRIEF.md
# NAND Flash Command/Address Sequencer

This block runs the command and address phases of an asynchronous NAND flash bus from the host side. A requester presents one operation and a one-clock valid strobe. The operation holds a first command code, an optional column/row address, an optional second command code, and a flag that marks a program or erase. The sequencer then drives chip enable, the command and address latch strobes, write enable, read enable and write protect. It places one byte at a time on the low byte of the I/O bus, and the device latches each byte on a rising edge of write enable.

Each write cycle has three phases: a setup phase with write enable high, a low phase, and a high phase during which the data is held. The length of each phase is a parameter counted in system clocks, so the strobes never form pulses narrow enough for the device to reject. The number of address cycles is chosen per request: none, four or five. Five cycles suit the larger parts. On the smallest part the fifth cycle is a dummy that the part ignores. The requester sees a busy level and a one-clock done pulse. A new request is taken only while the sequencer is idle.

Top module: `nand_cmd_seq`

## Requirements
- R1: While idle (and from reset) ce_n_o=1, cle_o=0, ale_o=0, we_n_o=1, io_oe_o=0, io_o=0, wp_n_o=0, busy_o=0 and done_o=0.
- R2: At the write-enable rising edge of a command cycle, ce_n_o=0, cle_o=1, ale_o=0 and io_o[7:0] holds the command code.
- R3: At the write-enable rising edge of an address cycle, ce_n_o=0, cle_o=0 and ale_o=1.
- R4: Address bytes go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, then row bits 23:16 as the fifth byte only.
- R5: With req_addr_en_i=1 there are 5 address cycles when cfg_five_cyc_i=1 and 4 when it is 0. With req_addr_en_i=0 there are none.
- R6: The byte order is the first command, then the address cycles, then the second command only when req_has_cmd2_i=1. No other bytes are strobed.
- R7: io_o[15:8] is 0 in every cycle.
- R8: wp_n_o is 1 for the whole sequence of a request with req_modify_i=1, and 0 throughout a request with req_modify_i=0.
- R9: re_n_o stays 1 at all times.
- R10: Write enable stays low for exactly WE_LO_CLKS clocks. The first write-enable fall comes SETUP_CLKS clocks after chip enable falls. Between two write-enable pulses write enable stays high for WE_HI_CLKS+SETUP_CLKS clocks. Bus values do not change at a rising edge of write enable.
- R11: done_o is high for exactly one clock after the final write cycle, and busy_o is 0 in the clock after that.
- R12: A request presented while busy_o=1 is ignored and produces no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-clock request strobe |
| req_cmd1_i | input | 8 | First command code |
| req_cmd2_i | input | 8 | Second command code |
| req_has_cmd2_i | input | 1 | Send the second command |
| req_addr_en_i | input | 1 | Send address cycles |
| req_col_i | input | 16 | Column address |
| req_row_i | input | 24 | Row address |
| req_modify_i | input | 1 | Program/erase request; raises write protect |
| cfg_five_cyc_i | input | 1 | 1: five address cycles, 0: four |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch strobe |
| ale_o | output | 1 | Address latch strobe |
| we_n_o | output | 1 | Write enable, active low |
| re_n_o | output | 1 | Read enable, active low |
| wp_n_o | output | 1 | Write protect, active low |
| io_o | output | 16 | I/O bus drive value |
| io_oe_o | output | 1 | I/O output enable |

## Verification
The hardest case to reach is a request that arrives in the middle of a running sequence. To leave any trace it would have to disturb the latched operation or add bytes after the expected ones. The bench therefore pulses a conflicting request during a write cycle. It then checks that the scoreboard queue drains exactly and that the bus stays idle after done. The second such condition is the write-protect level at every strobed byte of a modify request. It is reached by mixing erase and program requests with plain ones and checking the level at every write-enable rising edge, for both address-length settings.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_BYTES = 2;
  localparam int ROW_BYTES = 3;
  localparam int ADDR_MAX  = COL_BYTES + ROW_BYTES;
  localparam int SLOT_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SU,
    ST_LO,
    ST_HI,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/nand_byte_sel.sv
module nand_byte_sel
  import nand_seq_pkg::*;
(
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [SLOT_W-1:0]    nadr_i,
  input  logic [7:0]           cmd1_i,
  input  logic [7:0]           cmd2_i,
  input  logic [8*COL_BYTES-1:0] col_i,
  input  logic [8*ROW_BYTES-1:0] row_i,
  output logic [7:0]           byte_o,
  output logic                 cle_o,
  output logic                 ale_o
);
  logic [8*ADDR_MAX-1:0] addr_vec;
  logic [7:0]            addr_b [ADDR_MAX];
  logic [SLOT_W-1:0]     idx;
  logic [7:0]            abyte;
  logic                  is_cmd1, is_addr;

  // column first, low byte first
  assign addr_vec = {row_i, col_i};

  for (genvar k = 0; k < ADDR_MAX; k++) begin : g_ab
    assign addr_b[k] = addr_vec[8*k +: 8];
  end

  assign idx     = slot_i - 1'b1;
  assign is_cmd1 = (slot_i == '0);
  assign is_addr = !is_cmd1 && (slot_i <= nadr_i);

  always_comb begin
    abyte = '0;
    for (int k = 0; k < ADDR_MAX; k++)
      if (idx == SLOT_W'(k)) abyte = addr_b[k];
  end

  always_comb begin
    if (is_cmd1) begin
      byte_o = cmd1_i; cle_o = 1'b1; ale_o = 1'b0;
    end else if (is_addr) begin
      byte_o = abyte;  cle_o = 1'b0; ale_o = 1'b1;
    end else begin
      byte_o = cmd2_i; cle_o = 1'b1; ale_o = 1'b0;
    end
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int WE_LO_CLKS = 3,
  parameter int WE_HI_CLKS = 2,
  parameter int TW         = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [7:0]             req_cmd1_i,
  input  logic [7:0]             req_cmd2_i,
  input  logic                   req_has_cmd2_i,
  input  logic                   req_addr_en_i,
  input  logic [8*COL_BYTES-1:0] req_col_i,
  input  logic [8*ROW_BYTES-1:0] req_row_i,
  input  logic                   req_modify_i,
  input  logic                   cfg_five_cyc_i,
  input  logic                   tmr_last_i,
  output logic                   tmr_clr_o,
  output logic [TW-1:0]          tmr_lim_o,
  output seq_state_e             state_o,
  output logic [SLOT_W-1:0]      slot_o,
  output logic [SLOT_W-1:0]      nadr_o,
  output logic [7:0]             cmd1_o,
  output logic [7:0]             cmd2_o,
  output logic [8*COL_BYTES-1:0] col_o,
  output logic [8*ROW_BYTES-1:0] row_o,
  output logic                   modify_o
);
  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q, last_q, nadr_q;
  logic              adv, accept;
  logic [SLOT_W-1:0] nadr_d;

  assign accept = (state_q == ST_IDLE) && req_valid_i;
  assign adv    = tmr_last_i && (state_q inside {ST_SU, ST_LO, ST_HI});
  assign nadr_d = !req_addr_en_i ? '0 :
                  (cfg_five_cyc_i ? SLOT_W'(ADDR_MAX) : SLOT_W'(ADDR_MAX - 1));

  always_comb begin
    case (state_q)
      ST_SU:   tmr_lim_o = TW'(SETUP_CLKS);
      ST_LO:   tmr_lim_o = TW'(WE_LO_CLKS);
      ST_HI:   tmr_lim_o = TW'(WE_HI_CLKS);
      default: tmr_lim_o = TW'(1);
    endcase
  end
  assign tmr_clr_o = adv || !(state_q inside {ST_SU, ST_LO, ST_HI});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_q   <= '0;
      last_q   <= '0;
      nadr_q   <= '0;
      cmd1_o   <= '0;
      cmd2_o   <= '0;
      col_o    <= '0;
      row_o    <= '0;
      modify_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_SU;
          slot_q   <= '0;
          nadr_q   <= nadr_d;
          last_q   <= nadr_d + SLOT_W'(req_has_cmd2_i);
          cmd1_o   <= req_cmd1_i;
          cmd2_o   <= req_cmd2_i;
          col_o    <= req_col_i;
          row_o    <= req_row_i;
          modify_o <= req_modify_i;
        end
        ST_SU: if (adv) state_q <= ST_LO;
        ST_LO: if (adv) state_q <= ST_HI;
        ST_HI: if (adv) begin
          if (slot_q == last_q) state_q <= ST_DONE;
          else begin
            state_q <= ST_SU;
            slot_q  <= slot_q + 1'b1;
          end
        end
        ST_DONE: begin
          state_q  <= ST_IDLE;
          modify_o <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign slot_o  = slot_q;
  assign nadr_o  = nadr_q;

  // R12
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_SU, ST_LO, ST_HI}) |=> $stable(cmd1_o) && $stable(last_q));
  // R11
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int WE_LO_CLKS = 3,
  parameter int WE_HI_CLKS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [7:0]  req_cmd1_i,
  input  logic [7:0]  req_cmd2_i,
  input  logic        req_has_cmd2_i,
  input  logic        req_addr_en_i,
  input  logic [15:0] req_col_i,
  input  logic [23:0] req_row_i,
  input  logic        req_modify_i,
  input  logic        cfg_five_cyc_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        ce_n_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_n_o,
  output logic        re_n_o,
  output logic        wp_n_o,
  output logic [15:0] io_o,
  output logic        io_oe_o
);
  localparam int MAXC = (SETUP_CLKS > WE_LO_CLKS) ?
                        ((SETUP_CLKS > WE_HI_CLKS) ? SETUP_CLKS : WE_HI_CLKS) :
                        ((WE_LO_CLKS > WE_HI_CLKS) ? WE_LO_CLKS : WE_HI_CLKS);
  localparam int TW   = $clog2(MAXC + 1) + 1;

  seq_state_e        state;
  logic [SLOT_W-1:0] slot, nadr;
  logic [7:0]        cmd1, cmd2, sel_byte;
  logic [15:0]       col;
  logic [23:0]       row;
  logic              modify, sel_cle, sel_ale, in_cyc;
  logic              tmr_clr, tmr_last;
  logic [TW-1:0]     tmr_lim;

  nand_seq_fsm #(
    .SETUP_CLKS(SETUP_CLKS), .WE_LO_CLKS(WE_LO_CLKS),
    .WE_HI_CLKS(WE_HI_CLKS), .TW(TW)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_cmd1_i, .req_cmd2_i,
    .req_has_cmd2_i, .req_addr_en_i, .req_col_i, .req_row_i,
    .req_modify_i, .cfg_five_cyc_i,
    .tmr_last_i(tmr_last), .tmr_clr_o(tmr_clr), .tmr_lim_o(tmr_lim),
    .state_o(state), .slot_o(slot), .nadr_o(nadr),
    .cmd1_o(cmd1), .cmd2_o(cmd2), .col_o(col), .row_o(row),
    .modify_o(modify)
  );

  nand_phase_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .lim_i(tmr_lim), .last_o(tmr_last)
  );

  nand_byte_sel u_sel (
    .slot_i(slot), .nadr_i(nadr), .cmd1_i(cmd1), .cmd2_i(cmd2),
    .col_i(col), .row_i(row),
    .byte_o(sel_byte), .cle_o(sel_cle), .ale_o(sel_ale)
  );

  assign in_cyc  = state inside {ST_SU, ST_LO, ST_HI};
  assign ce_n_o  = !in_cyc;
  assign we_n_o  = (state != ST_LO);
  assign re_n_o  = 1'b1;
  assign cle_o   = in_cyc && sel_cle;
  assign ale_o   = in_cyc && sel_ale;
  assign io_oe_o = in_cyc;
  assign io_o    = in_cyc ? {8'h00, sel_byte} : 16'h0000;
  assign wp_n_o  = in_cyc && modify;
  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_DONE);

  // R2
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  // R8
  wp_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && $past(!ce_n_o)) |-> $stable(wp_n_o));
  // R10
  we_lo_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WE_LO_CLKS > 1 && $fell(we_n_o)) |=> !we_n_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o) && !ce_n_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R1
  idle_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_n_o && we_n_o && !io_oe_o && !cle_o && !ale_o && !wp_n_o));
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  localparam int SU = 2, LO = 3, HI = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_has2 = 0, req_aen = 0, req_mod = 0, cfg_five = 0;
  logic [7:0]  req_c1 = 0, req_c2 = 0;
  logic [15:0] req_col = 0;
  logic [23:0] req_row = 0;
  logic        busy, done, ce_n, cle, ale, we_n, re_n, wp_n, io_oe;
  logic [15:0] io;

  int checks = 0, errors = 0;
  int cyc = 0, t_fall = 0, t_rise = 0, t_cefall = 0, nbytes = 0;
  bit first_we = 1'b1;
  logic [10:0] exp_q[$];  // {wp, cle, ale, byte}

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  nand_cmd_seq #(.SETUP_CLKS(SU), .WE_LO_CLKS(LO), .WE_HI_CLKS(HI)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd1_i(req_c1),
    .req_cmd2_i(req_c2), .req_has_cmd2_i(req_has2), .req_addr_en_i(req_aen),
    .req_col_i(req_col), .req_row_i(req_row), .req_modify_i(req_mod),
    .cfg_five_cyc_i(cfg_five), .busy_o(busy), .done_o(done), .ce_n_o(ce_n),
    .cle_o(cle), .ale_o(ale), .we_n_o(we_n), .re_n_o(re_n), .wp_n_o(wp_n),
    .io_o(io), .io_oe_o(io_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R9
  always @(negedge re_n) if (rst_n) check(0, "R9", "re_n low", 0, 1);

  always @(negedge ce_n) t_cefall = cyc;

  // R10 timing monitor
  always @(negedge we_n) begin
    if (first_we) check(cyc - t_cefall == SU, "R10", "setup from ce fall", cyc - t_cefall, SU);
    else          check(cyc - t_rise == HI + SU, "R10", "we high gap", cyc - t_rise, HI + SU);
    first_we = 1'b0;
    t_fall = cyc;
  end

  // scoreboard monitor
  always @(posedge we_n) begin
    logic [10:0] e;
    t_rise = cyc;
    nbytes++;
    check(t_rise - t_fall == LO, "R10", "we low width", t_rise - t_fall, LO);
    check(ce_n == 0 && io_oe == 1, "R2", "ce_n/oe at strobe", {ce_n, io_oe}, 1);
    check(io[15:8] == 0, "R7", "upper io byte", io[15:8], 0);
    if (exp_q.size() == 0) check(0, "R6", "extra byte", io[7:0], 0);
    else begin
      e = exp_q.pop_front();
      if (e[9]) check({wp_n, cle, ale, io[7:0]} == e, "R2", "command cycle",
                      {wp_n, cle, ale, io[7:0]}, e);
      else      check({wp_n, cle, ale, io[7:0]} == e, "R3 R4", "address cycle",
                      {wp_n, cle, ale, io[7:0]}, e);
      check(wp_n == e[10], "R8", "wp level", wp_n, e[10]);
    end
  end

  task automatic run_req(input logic [7:0] c1, input bit has2, input logic [7:0] c2,
                         input bit aen, input bit five, input logic [15:0] col,
                         input logic [23:0] row, input bit md, input bit intrude);
    logic [39:0] av;
    int na, n0, w;
    av = {row, col};
    na = aen ? (five ? 5 : 4) : 0;
    exp_q.push_back({md, 1'b1, 1'b0, c1});
    for (int k = 0; k < na; k++) exp_q.push_back({md, 1'b0, 1'b1, av[8*k +: 8]});
    if (has2) exp_q.push_back({md, 1'b1, 1'b0, c2});
    n0 = nbytes;
    first_we = 1'b1;
    @(negedge clk);
    req_c1 = c1; req_has2 = has2; req_c2 = c2; req_aen = aen; cfg_five = five;
    req_col = col; req_row = row; req_mod = md; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1, "R11", "busy after accept", busy, 1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      req_c1 = 8'hEE; req_aen = 1'b0; req_has2 = 1'b1; req_mod = ~md; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 500) begin @(negedge clk); w++; end
    check(done == 1, "R11", "done seen", done, 1);
    @(negedge clk);
    check(done == 0 && busy == 0, "R11", "done one clock then idle", {done, busy}, 0);
    check(nbytes - n0 == na + 1 + int'(has2), "R5 R6", "byte count", nbytes - n0, na + 1 + int'(has2));
    check(exp_q.size() == 0, "R6", "queue drained", exp_q.size(), 0);
    exp_q.delete();
    repeat (6) @(negedge clk);
    check(busy == 0 && ce_n == 1, "R12", "stays idle after done", {busy, ce_n}, 2'b01);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset levels
    check({ce_n, cle, ale, we_n, io_oe, wp_n, busy, done} == 8'b10010000, "R1",
          "reset levels", {ce_n, cle, ale, we_n, io_oe, wp_n, busy, done}, 8'b10010000);
    check(io == 0, "R1", "io idle", io, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({ce_n, cle, ale, we_n, io_oe, wp_n, busy} == 7'b1001000, "R1",
          "idle levels", {ce_n, cle, ale, we_n, io_oe, wp_n, busy}, 7'b1001000);
    check(re_n == 1, "R9", "re_n idle", re_n, 1);
    // read-like, five cycles (R4 R5)
    run_req(8'h00, 1, 8'h30, 1, 1, 16'hB2A1, 24'hE5D4C3, 0, 0);
    // four cycles (R5)
    run_req(8'h00, 1, 8'h30, 1, 0, 16'h1234, 24'h00AB56, 0, 0);
    // erase, modify, five cycles (R8)
    run_req(8'h60, 1, 8'hD0, 1, 1, 16'h0000, 24'h03F2E1, 1, 0);
    // command only (R6)
    run_req(8'hFF, 0, 8'h00, 0, 1, 16'hFFFF, 24'hFFFFFF, 0, 0);
    // program, modify, four cycles, no second command
    run_req(8'h80, 0, 8'h10, 1, 0, 16'h0F0E, 24'h0D0C0B, 1, 0);
    // request while busy is ignored (R12)
    run_req(8'h90, 1, 8'h70, 1, 1, 16'h5544, 24'h887766, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule